// File: doc/BRIEF.md
# PS/2 Host Register Interface

This block sits between a processor bus and one PS/2 channel, which may carry a keyboard or a mouse. Software sees a small set of 32-bit word registers on a simple APB-style slave port. These are a control word, a receive status word, a data port, a clock divisor and an interrupt status word. A read-only identification window sits at the top of the 4 KiB page. Toward the device, the block takes received bytes from a PS/2 serial engine and sends bytes for that engine to shift out. The serial engine itself is not part of this block.

A received byte is held in a one-entry staging register and raises a pending flag. Reading the data port while the flag is set moves the staged byte into the last-byte register, returns it and clears the flag. Reading the data port with nothing pending returns the last byte again. One level-sensitive interrupt line combines the pending flag with two enable bits of the control word.

Top module: `ps2h_host_regs`

## Requirements
- R1: A synchronous active-high reset clears the control word, the clock divisor, the held bytes and the pending flag. After reset, control, divisor, status, data and interrupt status read 0, 0, 0, 0 and 0x2, and `irq` is low.
- R2: The register index is address bits [11:2]. Index 0 is the control word and index 3 is the clock divisor. Both store and read back all 32 written bits. The divisor has no other effect.
- R3: Byte addresses 0xFE0 to 0xFFC, one per word, read the identification bytes 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended to 32 bits.
- R4: `irq` equals (pending AND control bit 4) OR control bit 3. Control bit 3 alone asserts it, whether or not anything is pending.
- R5: The status word (index 1) reads 0x10 while a received byte is pending and 0 otherwise.
- R6: A data read (index 2) while a byte is pending returns that byte and clears the pending flag after the access.
- R7: A data read with nothing pending returns the last byte returned, without changing it.
- R8: A byte arriving on `rx_valid` in the same cycle as a consuming data read is kept. The read returns the older byte, the flag stays set, and the next data read returns the new byte.
- R9: The interrupt status word (index 4) reads the pending flag in bit 0 and a constant 1 in bit 1, with all other bits zero.
- R10: A control write takes effect on `irq` from the first cycle after the write access.
- R11: A data write while `tx_busy` is low produces exactly one cycle of `tx_valid`, starting in the first cycle after the access, with `tx_byte` equal to the low byte written.
- R12: A data write while `tx_busy` is high is dropped, and `tx_valid` stays low.
- R13: Writes to status, interrupt status, the identification window or unused offsets change no register: control, divisor, status and `irq` keep their values.
- R14: Reads of unused offsets (index 5 up to the identification window) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the page |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_busy | input | 1 | Serial engine cannot accept a byte |
| tx_valid | output | 1 | One-cycle strobe carrying `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The case hardest to reach from the ports is a byte arriving in the exact cycle that a data read consumes the previous one. Set must beat clear there, and the read must still return the older byte. The bench raises `rx_valid` on the same falling edge that raises `penable` for the data read. It then checks the returned byte, the status word and a second data read. The interrupt equation is swept over all four settings of the two enable bits, each with the flag set and with it clear. The identification window and a spread of unused offsets are swept by address.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_STAT,
        SEL_DATA,
        SEL_CDIV,
        SEL_ISTAT,
        SEL_ID,
        SEL_NONE
    } reg_sel_e;

    // control word bit positions
    localparam int CTRL_RXIE_BIT = 4;
    localparam int CTRL_TXIE_BIT = 3;
    // status word bit position of the pending flag
    localparam int STAT_PEND_BIT = 4;

endpackage

// File: rtl/ps2h_decode.sv
module ps2h_decode
    import ps2h_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int ID_BASE  = 'hFE0,
    parameter int ID_BYTES = 8,
    localparam int IDX_W   = $clog2(ID_BYTES)
) (
    input  logic [ADDR_W-1:0] paddr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  id_idx
);

    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(ID_BASE);
    localparam int ID_END = ID_BASE + 4 * ID_BYTES;

    logic [ADDR_W-3:0] word_idx;
    logic [ADDR_W-1:0] id_off;
    logic              in_id;
    logic              unused_low;

    assign word_idx   = paddr[ADDR_W-1:2];
    assign id_off     = paddr - BASE_V;
    assign id_idx     = id_off[2 +: IDX_W];
    assign in_id      = (int'(paddr) >= ID_BASE) && (int'(paddr) < ID_END);
    assign unused_low = ^{paddr[1:0], id_off};

    always_comb begin
        if (in_id) begin
            sel = SEL_ID;
        end else begin
            case (word_idx)
                (ADDR_W-2)'(0): sel = SEL_CTRL;
                (ADDR_W-2)'(1): sel = SEL_STAT;
                (ADDR_W-2)'(2): sel = SEL_DATA;
                (ADDR_W-2)'(3): sel = SEL_CDIV;
                (ADDR_W-2)'(4): sel = SEL_ISTAT;
                default:        sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ps2h_id_rom.sv
module ps2h_id_rom #(
    parameter int ID_BYTES = 8,
    localparam int IDX_W   = $clog2(ID_BYTES)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       id_byte
);

    always_comb begin
        case (idx)
            IDX_W'(0): id_byte = 8'h50;
            IDX_W'(1): id_byte = 8'h10;
            IDX_W'(2): id_byte = 8'h04;
            IDX_W'(3): id_byte = 8'h00;
            IDX_W'(4): id_byte = 8'h0D;
            IDX_W'(5): id_byte = 8'hF0;
            IDX_W'(6): id_byte = 8'h05;
            IDX_W'(7): id_byte = 8'hB1;
            default:   id_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/ps2h_rx_hold.sv
module ps2h_rx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              take,
    output logic              pending,
    output logic [BYTE_W-1:0] rd_byte
);

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] stage;
        logic [BYTE_W-1:0] last;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take && st_q.pend) begin
            st_d.last = st_q.stage;
            st_d.pend = 1'b0;
        end
        // a new arrival wins over the consuming read
        if (rx_valid) begin
            st_d.stage = rx_byte;
            st_d.pend  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pending = st_q.pend;
    assign rd_byte = st_q.pend ? st_q.stage : st_q.last;

endmodule

// File: rtl/ps2h_irq.sv
module ps2h_irq
    import ps2h_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] ctrl,
    input  logic              pending,
    output logic              irq
);

    logic unused_ctrl;
    assign unused_ctrl = ^ctrl;
    assign irq = (pending & ctrl[CTRL_RXIE_BIT]) | ctrl[CTRL_TXIE_BIT];

endmodule

// File: rtl/ps2h_host_regs.sv
module ps2h_host_regs
    import ps2h_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int BYTE_W   = 8,
    parameter int ID_BASE  = 'hFE0,
    parameter int ID_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_busy,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);

    localparam int IDX_W = $clog2(ID_BYTES);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] cdiv;
        logic              txv;
        logic [BYTE_W-1:0] txb;
    } host_state_t;

    host_state_t st_d, st_q;

    reg_sel_e          sel;
    logic [IDX_W-1:0]  id_idx;
    logic [7:0]        id_byte;
    logic              acc_wr;
    logic              acc_rd;
    logic              rx_pend;
    logic [BYTE_W-1:0] rx_rd_byte;
    logic [DATA_W-1:0] ctrl_q;

    assign acc_wr = psel & penable & pwrite;
    assign acc_rd = psel & penable & ~pwrite;

    ps2h_decode #(
        .ADDR_W  (ADDR_W),
        .ID_BASE (ID_BASE),
        .ID_BYTES(ID_BYTES)
    ) u_decode (
        .paddr (paddr),
        .sel   (sel),
        .id_idx(id_idx)
    );

    ps2h_id_rom #(
        .ID_BYTES(ID_BYTES)
    ) u_id_rom (
        .idx    (id_idx),
        .id_byte(id_byte)
    );

    ps2h_rx_hold #(
        .BYTE_W(BYTE_W)
    ) u_rx_hold (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .take    (acc_rd && (sel == SEL_DATA)),
        .pending (rx_pend),
        .rd_byte (rx_rd_byte)
    );

    always_comb begin
        st_d     = st_q;
        st_d.txv = 1'b0;
        if (acc_wr) begin
            case (sel)
                SEL_CTRL: st_d.ctrl = pwdata;
                SEL_CDIV: st_d.cdiv = pwdata;
                SEL_DATA: begin
                    if (!tx_busy) begin
                        st_d.txv = 1'b1;
                        st_d.txb = pwdata[BYTE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_CTRL:  prdata = st_q.ctrl;
                SEL_STAT:  prdata[STAT_PEND_BIT] = rx_pend;
                SEL_DATA:  prdata = DATA_W'(rx_rd_byte);
                SEL_CDIV:  prdata = st_q.cdiv;
                SEL_ISTAT: prdata = {{(DATA_W-2){1'b0}}, 1'b1, rx_pend};
                SEL_ID:    prdata = DATA_W'(id_byte);
                default:   prdata = '0;
            endcase
        end
    end

    ps2h_irq #(
        .DATA_W(DATA_W)
    ) u_irq (
        .ctrl   (st_q.ctrl),
        .pending(rx_pend),
        .irq    (irq)
    );

    assign ctrl_q   = st_q.ctrl;
    assign tx_valid = st_q.txv;
    assign tx_byte  = st_q.txb;

endmodule

// File: rtl/ps2h_host_regs_chk.sv
module ps2h_host_regs_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              rx_valid,
    input logic              tx_busy,
    input logic              tx_valid,
    input logic              irq,
    input logic              rx_pend,
    input logic [DATA_W-1:0] ctrl_q
);

    logic data_wr;
    logic ctrl_wr;
    logic stat_rd;
    assign data_wr = psel && penable && pwrite && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(2));
    assign ctrl_wr = psel && penable && pwrite && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(0));
    assign stat_rd = psel && !pwrite && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(1));

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_q[3] || rx_pend)); // R4

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> (prdata == '0 || prdata == DATA_W'(32'h10))); // R5

    AST_ARRIVAL_SETS: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rx_pend); // R8

    AST_CTRL_STORE: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl_q == $past(pwdata))); // R10

    AST_TX_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(data_wr && !tx_busy)); // R11

    AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
        (data_wr && tx_busy) |=> !tx_valid); // R12

endmodule

bind ps2h_host_regs ps2h_host_regs_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .rx_valid(rx_valid),
    .tx_busy (tx_busy),
    .tx_valid(tx_valid),
    .irq     (irq),
    .rx_pend (rx_pend),
    .ctrl_q  (ctrl_q)
);

// File: tb/ps2h_host_regs_tb.sv
module ps2h_host_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_busy = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    ps2h_host_regs u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_busy(tx_busy), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // optional byte arrival in the same cycle as the access phase
    task automatic bus_read(input logic [11:0] a, output logic [31:0] d,
                            input bit push, input logic [7:0] pb);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        if (push) begin rx_valid = 1'b1; rx_byte = pb; end
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [7:0]  id_exp [8];
        logic [7:0]  last;
        id_exp = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(12'h000, r, 0, 0); check("R1 ctrl", r, 0);
        bus_read(12'h00C, r, 0, 0); check("R1 cdiv", r, 0);
        bus_read(12'h004, r, 0, 0); check("R1 status", r, 0);
        bus_read(12'h008, r, 0, 0); check("R1 data", r, 0);
        bus_read(12'h010, r, 0, 0); check("R1 istat", r, 32'h2);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 full-width storage, walking patterns
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            v = 32'hA5C3_0F17 ^ (32'h1 << (i * 4)) ^ (i * 32'h0101_0101);
            v[4:3] = 2'b00;
            bus_write(12'h000, v); bus_read(12'h000, r, 0, 0); check("R2 ctrl", r, v);
            bus_write(12'h00C, ~v); bus_read(12'h00C, r, 0, 0); check("R2 cdiv", r, ~v);
        end
        bus_write(12'h000, 0);

        // R3 identification window
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(i * 4), r, 0, 0);
            check("R3 id", r, {24'b0, id_exp[i]});
        end

        // R14 unused offsets
        for (int i = 0; i < 8; i++) begin
            logic [11:0] a;
            a = 12'h014 + 12'(i * 12'h1F4);
            if (a >= 12'hFE0) a = 12'hFDC;
            bus_read(a, r, 0, 0); check("R14 unused", r, 0);
        end

        // R4 / R10 interrupt sweep: enables x pending
        for (int e = 0; e < 4; e++) begin
            for (int p = 0; p < 2; p++) begin
                logic exp_irq;
                if (p == 1) rx_push(8'h3C);
                bus_write(12'h000, 32'(e) << 3);
                @(negedge clk);
                exp_irq = (p == 1 && e[1]) || e[0];
                check("R4 R10 irq", {31'b0, irq}, {31'b0, exp_irq});
                if (p == 1) bus_read(12'h008, r, 0, 0);
            end
        end
        bus_write(12'h000, 0);

        // R5 R6 R7 R9 data path sweep
        last = 8'h3C;
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b;
            b = 8'(i * 37 + 5);
            rx_push(b);
            bus_read(12'h004, r, 0, 0); check("R5 status set", r, 32'h10);
            bus_read(12'h010, r, 0, 0); check("R9 istat set", r, 32'h3);
            bus_read(12'h008, r, 0, 0); check("R6 data take", r, {24'b0, b});
            bus_read(12'h004, r, 0, 0); check("R5 status clear", r, 0);
            bus_read(12'h010, r, 0, 0); check("R9 istat clear", r, 32'h2);
            bus_read(12'h008, r, 0, 0); check("R7 data repeat", r, {24'b0, b});
            last = b;
        end

        // R8 arrival in the consuming cycle
        rx_push(8'h11);
        bus_read(12'h008, r, 1, 8'h22); check("R8 older byte", r, 32'h11);
        bus_read(12'h004, r, 0, 0);    check("R8 still pending", r, 32'h10);
        bus_read(12'h008, r, 0, 0);    check("R8 newer byte", r, 32'h22);
        bus_read(12'h004, r, 0, 0);    check("R8 drained", r, 0);

        // R11 transmit pulse
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            w = 32'hDEAD_BE00 | 32'(8'h5A + i * 17);
            @(negedge clk);
            psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h008; pwdata = w;
            @(negedge clk);
            penable = 1'b1;
            check("R11 idle before", {31'b0, tx_valid}, 0);
            @(negedge clk);
            psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
            check("R11 valid", {31'b0, tx_valid}, 1);
            check("R11 byte", {24'b0, tx_byte}, {24'b0, w[7:0]});
            @(negedge clk);
            check("R11 one cycle", {31'b0, tx_valid}, 0);
        end

        // R12 write while busy
        tx_busy = 1'b1;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h008; pwdata = 32'h77;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        check("R12 dropped", {31'b0, tx_valid}, 0);
        @(negedge clk);
        check("R12 still low", {31'b0, tx_valid}, 0);
        tx_busy = 1'b0;

        // R13 writes to read-only and unused offsets
        bus_write(12'h000, 32'h0000_0100);
        bus_write(12'h00C, 32'h0000_BEEF);
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_write(12'hFE0, 32'hFFFF_FFFF);
        bus_write(12'h020, 32'hFFFF_FFFF);
        bus_read(12'h000, r, 0, 0); check("R13 ctrl kept", r, 32'h100);
        bus_read(12'h00C, r, 0, 0); check("R13 cdiv kept", r, 32'hBEEF);
        bus_read(12'h004, r, 0, 0); check("R13 status kept", r, 0);
        bus_read(12'hFE0, r, 0, 0); check("R13 id kept", r, 32'h50);
        check("R13 irq low", {31'b0, irq}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule